// File: doc/BRIEF.md
# Dual-Thread Idle State Resolver

This block merges the idle requests of two hardware threads into a single package power-state request. A thread asks to go idle in one of two ways. It can issue a direct idle-wait request that carries a state hint. It can also read one of the power-level registers; the block turns that read into the idle-wait hint held in a programmable configuration field, and no bus cycle results. Either way the request becomes a thread state of TC0, TC1, TC2, TC4 or TC6. The thread keeps that state until it makes a new request or sees a break event.

The package state is the shallowest state that both threads share. Two extra inputs can deepen it. The L2 active-way count and the enhanced-deeper-sleep enables raise a shared C4 to C5, and the way count alone allows a shared TC6 to become C6. A second output tells the bus logic when a stop-grant acknowledge may be issued. Voltage control, cache flushing and state saving are done elsewhere. Only their effects reach this block, as the way count and the enable bits.

Top module: `idle_resolver`

## Requirements
- R1: After reset both thread states read TC0 (code 0), `pkg_state` reads C0 (code 0) and `sg_ack_ok` is 0.
- R2: An idle-wait request maps its 3-bit hint to a thread state: 0→TC0, 1→TC1, 2→TC2, 3/4/5→TC4, 6/7→TC6. Thread states are coded TC0=0, TC1=1, TC2=2, TC4=4, TC6=6, and thread i sits in `thr_state[3i+2:3i]`.
- R3: A power-level read (`req_is_lvl`=1) ignores `req_hint` and takes the hint from field `cfg_lvl_hint[3k+2:3k]`, where k is the thread's `req_lvl`. The R2 mapping then applies.
- R4: The package state is the lower of the two thread states: any TC0 gives C0, TC1 with anything deeper gives C1, and TC2 with TC2 or deeper gives C2. Package codes are C0=0, C1=1, C2=2, C4=4, C5=5, C6=6.
- R5: With both threads at TC4 or deeper but not both at TC6, the result is C5 when `l2_ways` is 0 and both `edeep_en` and `dcs_en` are 1. Otherwise it is C4.
- R6: With both threads at TC6, the result is C6 when `l2_ways` is 0 and C4 otherwise. One thread at TC6 is never enough for C6.
- R7: `sg_ack_ok` is 1 only when the resolved state is C2 or deeper and `stpclk_req` was 1 in the same input cycle.
- R8: A break on a thread forces that thread to TC0 at the next clock edge, even when the thread makes a request in the same cycle.
- R9: Thread states and outputs update on the first clock edge after their inputs change. With no request and no break, a thread keeps its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | NTHR | Idle request strobe, one bit per thread |
| req_is_lvl | input | NTHR | 1: power-level read, 0: idle-wait request |
| req_hint | input | NTHR*3 | Idle-wait hint, 3 bits per thread |
| req_lvl | input | NTHR*LVL_W | Power-level register index per thread |
| brk | input | NTHR | Break event per thread |
| cfg_lvl_hint | input | (2**LVL_W)*3 | Hint per power-level register |
| l2_ways | input | WAYS_W | L2 active-way count |
| dcs_en | input | 1 | Cache-sizing enable |
| edeep_en | input | 1 | Enhanced deeper sleep enable |
| stpclk_req | input | 1 | External stop-clock request |
| thr_state | output | NTHR*3 | Current thread states |
| pkg_state | output | 3 | Resolved package state |
| sg_ack_ok | output | 1 | Stop-grant acknowledge permitted |

## Verification
A break and a new request can reach the same thread in the same cycle. The bench sets up that collision by sending a TC6 hint and a break to one thread on the same edge. It passes only if that thread reads TC0 and the package reads C0, which shows the break won. A second collision comes from a change in the L2 way count while both thread states stay fixed. The bench checks that the package moves from C4 to C5 on the single edge after the count reaches zero.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int ST_W = 3;

  localparam logic [ST_W-1:0] TS_C0 = 3'd0;
  localparam logic [ST_W-1:0] TS_C1 = 3'd1;
  localparam logic [ST_W-1:0] TS_C2 = 3'd2;
  localparam logic [ST_W-1:0] TS_C4 = 3'd4;
  localparam logic [ST_W-1:0] TS_C6 = 3'd6;

  localparam logic [ST_W-1:0] PK_C0 = 3'd0;
  localparam logic [ST_W-1:0] PK_C2 = 3'd2;
  localparam logic [ST_W-1:0] PK_C4 = 3'd4;
  localparam logic [ST_W-1:0] PK_C5 = 3'd5;
  localparam logic [ST_W-1:0] PK_C6 = 3'd6;

  // Hint to thread state; a C3 hint lands on TC4.
  function automatic logic [ST_W-1:0] hint_to_state(input logic [ST_W-1:0] h);
    logic [ST_W-1:0] s;
    case (h)
      3'd0:                s = TS_C0;
      3'd1:                s = TS_C1;
      3'd2:                s = TS_C2;
      3'd3, 3'd4, 3'd5:    s = TS_C4;
      default:             s = TS_C6;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/idle_thread_slot.sv
module idle_thread_slot
  import idle_pkg::*;
#(
  parameter int LVL_W = 2,
  localparam int CFG_W = (1 << LVL_W) * ST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic             req_is_lvl,
  input  logic [ST_W-1:0]  req_hint,
  input  logic [LVL_W-1:0] req_lvl,
  input  logic [CFG_W-1:0] cfg_hints,
  input  logic             brk,
  output logic [ST_W-1:0]  st_q,
  output logic [ST_W-1:0]  st_d
);
  logic [ST_W-1:0] eff_hint;
  logic            ld_en;

  always_comb begin
    eff_hint = req_is_lvl ? cfg_hints[int'(req_lvl)*ST_W +: ST_W] : req_hint;
    ld_en    = brk | req_vld;
    st_d     = st_q;
    if (brk)
      st_d = TS_C0;
    else if (req_vld)
      st_d = hint_to_state(eff_hint);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= TS_C0;
    else if (ld_en)
      st_q <= st_d;
  end

  // R8
  brk_to_tc0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> (st_q == TS_C0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!brk && !req_vld) |=> $stable(st_q));

  // R2
  legal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TS_C0) || (st_q == TS_C1) || (st_q == TS_C2) ||
    (st_q == TS_C4) || (st_q == TS_C6));
endmodule

// File: rtl/idle_pkg_resolve.sv
module idle_pkg_resolve
  import idle_pkg::*;
#(
  parameter int NTHR   = 2,
  parameter int WAYS_W = 4
) (
  input  logic [NTHR*ST_W-1:0] st_vec,
  input  logic [WAYS_W-1:0]    l2_ways,
  input  logic                 edeep_en,
  input  logic                 dcs_en,
  output logic [ST_W-1:0]      pkg_d
);
  logic [ST_W-1:0] shallow;
  logic            l2_empty;
  logic            edeep_ok;

  always_comb begin
    shallow = 3'd7;
    for (int i = 0; i < NTHR; i++) begin
      if (st_vec[i*ST_W +: ST_W] < shallow)
        shallow = st_vec[i*ST_W +: ST_W];
    end
    l2_empty = (l2_ways == '0);
    edeep_ok = edeep_en & dcs_en;
    case (shallow)
      TS_C4:   pkg_d = (l2_empty && edeep_ok) ? PK_C5 : PK_C4;
      TS_C6:   pkg_d = l2_empty ? PK_C6 : PK_C4;
      default: pkg_d = shallow;
    endcase
  end
endmodule

// File: rtl/idle_resolver.sv
module idle_resolver
  import idle_pkg::*;
#(
  parameter int NTHR   = 2,
  parameter int WAYS_W = 4,
  parameter int LVL_W  = 2,
  localparam int CFG_W = (1 << LVL_W) * 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTHR-1:0]       req_vld,
  input  logic [NTHR-1:0]       req_is_lvl,
  input  logic [NTHR*3-1:0]     req_hint,
  input  logic [NTHR*LVL_W-1:0] req_lvl,
  input  logic [NTHR-1:0]       brk,
  input  logic [CFG_W-1:0]      cfg_lvl_hint,
  input  logic [WAYS_W-1:0]     l2_ways,
  input  logic                  dcs_en,
  input  logic                  edeep_en,
  input  logic                  stpclk_req,
  output logic [NTHR*3-1:0]     thr_state,
  output logic [2:0]            pkg_state,
  output logic                  sg_ack_ok
);
  logic [1:0]           rs_q;
  logic                 rst_int_n;
  logic [NTHR*ST_W-1:0] st_next;
  logic [ST_W-1:0]      pkg_d;
  logic                 ack_d;
  logic                 out_en;

  // Reset asserts at once, releases after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rs_q <= 2'b00;
    else
      rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    idle_thread_slot #(.LVL_W(LVL_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .req_vld    (req_vld[t]),
      .req_is_lvl (req_is_lvl[t]),
      .req_hint   (req_hint[t*3 +: 3]),
      .req_lvl    (req_lvl[t*LVL_W +: LVL_W]),
      .cfg_hints  (cfg_lvl_hint),
      .brk        (brk[t]),
      .st_q       (thr_state[t*3 +: 3]),
      .st_d       (st_next[t*ST_W +: ST_W])
    );
  end

  idle_pkg_resolve #(.NTHR(NTHR), .WAYS_W(WAYS_W)) u_res (
    .st_vec   (st_next),
    .l2_ways  (l2_ways),
    .edeep_en (edeep_en),
    .dcs_en   (dcs_en),
    .pkg_d    (pkg_d)
  );

  always_comb begin
    ack_d  = (pkg_d >= PK_C2) && stpclk_req;
    out_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pkg_state <= PK_C0;
      sg_ack_ok <= 1'b0;
    end else if (out_en) begin
      pkg_state <= pkg_d;
      sg_ack_ok <= ack_d;
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_chk
    // R4
    tc0_forces_c0_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (thr_state[t*3 +: 3] == TS_C0) |-> (pkg_state == PK_C0));
    // R6
    c6_needs_all_tc6_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      (pkg_state == PK_C6) |-> (thr_state[t*3 +: 3] == TS_C6));
  end

  // R6
  c6_needs_empty_l2_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pkg_state == PK_C6) |-> ($past(l2_ways) == '0));

  // R5
  c5_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pkg_state == PK_C5) |-> $past(edeep_en && dcs_en && (l2_ways == '0)));

  // R7
  ack_needs_stpclk_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    sg_ack_ok |-> ($past(stpclk_req) && (pkg_state >= PK_C2)));
endmodule

// File: tb/idle_resolver_bench.sv
module idle_resolver_bench;
  localparam int NTHR = 2;
  localparam int WAYS_W = 4;
  localparam int LVL_W = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  req_vld, req_is_lvl, brk;
  logic [5:0]  req_hint;
  logic [3:0]  req_lvl;
  logic [11:0] cfg_lvl_hint;
  logic [3:0]  l2_ways;
  logic        dcs_en, edeep_en, stpclk_req;
  logic [5:0]  thr_state;
  logic [2:0]  pkg_state;
  logic        sg_ack_ok;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  idle_resolver #(.NTHR(NTHR), .WAYS_W(WAYS_W), .LVL_W(LVL_W)) u_idle_resolver (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_is_lvl(req_is_lvl),
    .req_hint(req_hint), .req_lvl(req_lvl), .brk(brk),
    .cfg_lvl_hint(cfg_lvl_hint), .l2_ways(l2_ways), .dcs_en(dcs_en),
    .edeep_en(edeep_en), .stpclk_req(stpclk_req), .thr_state(thr_state),
    .pkg_state(pkg_state), .sg_ack_ok(sg_ack_ok)
  );

  // {h0, h1, ways, edeep, dcs, stpclk, exp_pkg, exp_ack}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {3'd2, 3'd2, 4'd8, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0}, // R4 shared TC2
    {3'd2, 3'd2, 4'd8, 1'b0, 1'b0, 1'b1, 3'd2, 1'b1}, // R7 ack in C2
    {3'd1, 3'd4, 4'd8, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0}, // R7 no ack in C1
    {3'd0, 3'd6, 4'd0, 1'b1, 1'b1, 1'b1, 3'd0, 1'b0}, // R4 TC0 wins
    {3'd3, 3'd4, 4'd0, 1'b1, 1'b1, 1'b1, 3'd5, 1'b1}, // R2 C3 hint, R5 C5
    {3'd4, 3'd4, 4'd0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0}, // R5 dcs off
    {3'd4, 3'd4, 4'd3, 1'b1, 1'b1, 1'b0, 3'd4, 1'b0}, // R5 ways left
    {3'd6, 3'd6, 4'd0, 1'b0, 1'b0, 1'b0, 3'd6, 1'b0}, // R6 C6
    {3'd6, 3'd6, 4'd2, 1'b1, 1'b1, 1'b0, 3'd4, 1'b0}, // R6 ways left
    {3'd6, 3'd4, 4'd0, 1'b1, 1'b1, 1'b0, 3'd5, 1'b0}, // R6 single TC6
    {3'd7, 3'd5, 4'd0, 1'b0, 1'b0, 1'b1, 3'd4, 1'b1}, // R2 hints 7,5
    {3'd2, 3'd6, 4'd0, 1'b1, 1'b1, 1'b0, 3'd2, 1'b0}  // R4 TC2 vs TC6
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    req_vld = 2'b00; req_is_lvl = 2'b00; brk = 2'b00;
  endtask

  // Issue idle-wait hints on both threads for one edge; sample afterwards.
  task automatic wait_req(input logic [2:0] h0, input logic [2:0] h1);
    @(negedge clk);
    req_vld = 2'b11; req_is_lvl = 2'b00; req_hint = {h1, h0};
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; idle_inputs(); req_hint = '0; req_lvl = '0;
    cfg_lvl_hint = '0; l2_ways = 4'd8; dcs_en = 0; edeep_en = 0; stpclk_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 thr_state", thr_state, 0);
    chk("R1 pkg_state", pkg_state, 0);
    chk("R1 sg_ack_ok", sg_ack_ok, 0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      l2_ways = VEC[v][10:7]; edeep_en = VEC[v][6]; dcs_en = VEC[v][5];
      stpclk_req = VEC[v][4];
      req_vld = 2'b11; req_is_lvl = 2'b00;
      req_hint = {VEC[v][13:11], VEC[v][16:14]};
      @(negedge clk);
      idle_inputs();
      chk($sformatf("R4/R5/R6 vector %0d pkg", v), pkg_state, VEC[v][3:1]);
      chk($sformatf("R7 vector %0d ack", v), sg_ack_ok, VEC[v][0]);
    end

    // R3: power-level reads use configured hints, req_hint ignored.
    stpclk_req = 0; l2_ways = 4'd8;
    @(negedge clk);
    cfg_lvl_hint = {3'd1, 3'd6, 3'd4, 3'd2};
    req_vld = 2'b11; req_is_lvl = 2'b11; req_hint = {3'd0, 3'd0};
    req_lvl = {2'd1, 2'd2};
    @(negedge clk);
    idle_inputs();
    chk("R3 level read thread states", thr_state, {3'd4, 3'd6});
    chk("R3 level read pkg", pkg_state, 4);
    @(negedge clk);
    req_vld = 2'b10; req_is_lvl = 2'b10; req_lvl = {2'd3, 2'd0};
    @(negedge clk);
    idle_inputs();
    chk("R3 level index 3 thread1", thr_state[5:3], 1);
    chk("R3 level index 3 pkg", pkg_state, 1);
    // R9: no request, state held.
    @(negedge clk);
    chk("R9 hold thread states", thr_state, {3'd1, 3'd6});

    // R9/R5: way count alone moves the package on one edge.
    edeep_en = 1; dcs_en = 1; l2_ways = 4'd1;
    wait_req(3'd4, 3'd4);
    chk("R5 ways one gives C4", pkg_state, 4);
    l2_ways = 4'd0;
    @(negedge clk);
    chk("R9 ways zero after one edge gives C5", pkg_state, 5);

    // R8: break beats a same-cycle request.
    wait_req(3'd2, 3'd2);
    chk("R8 setup pkg C2", pkg_state, 2);
    @(negedge clk);
    req_vld = 2'b01; req_hint = {3'd2, 3'd6}; brk = 2'b01;
    @(negedge clk);
    idle_inputs();
    chk("R8 break thread0", thr_state[2:0], 0);
    chk("R8 break pkg", pkg_state, 0);
    brk = 2'b10;
    @(negedge clk);
    idle_inputs();
    chk("R8 break thread1 alone", thr_state[5:3], 0);

    summary();
  end
endmodule